// File: doc/BRIEF.md
# Indexed codec control register file

This block is the device side of a small host interface for an audio codec. The host sees four byte-wide ports at consecutive offsets: an index port, a data port, a status port and a polled port. It writes a register number and a mode-change-enable flag into the index port. It then reads or writes the selected indirect register through the data port. The block holds thirty-two indirect registers, their reset contents and their read-only fields. It also models the timing side of the codec. A busy period follows power-on and every accepted format change, and during it the index port reads 0x80. A calibration period starts when mode-change-enable is cleared, and register 11 reports it.

Register 12 carries a mode flag. In legacy mode only sixteen registers exist, and indices 16 to 31 fold onto 0 to 15. In extended mode all thirty-two registers are separate. The host bus is a synchronous strobe with a write flag, a 2-bit port address and 8-bit data. Read data is registered and appears the cycle after the read strobe.

Top module: `codec_ctl_regs`

## Requirements
- R1: After reset, registers 0 to 15 hold 08,08,08,08,08,08,00,00,00,08,02,00,CA,00,00,00 (hex), and registers 16 to 31 hold 00.
- R2: A write to port 0 stores bits 4:0 as the index and bit 6 as mode-change-enable. When the block is not busy, a read of port 0 returns {0, mce, 0, index}. Both fields are 0 after reset.
- R3: While the block is busy, a read of port 0 returns 0x80. The block is busy for INIT_CYCLES cycles after reset.
- R4: A port 1 access reaches the register chosen by the last index written. Read data appears on bus_rdata the cycle after the read strobe and is held until the next read.
- R5: A write to register 8 (format) takes effect only while mode-change-enable is 1. With mode-change-enable at 0 it leaves the register unchanged.
- R6: An accepted format write makes the block busy for RESYNC_CYCLES cycles. After that, port 0 reads normally again.
- R7: A port 1 write that arrives while the block is busy changes no register.
- R8: A port 0 write that clears mode-change-enable when it was 1, while register 9 bit 3 is 1, starts calibration. Register 11 bit 5 then reads 1 for CAL_CYCLES cycles and 0 afterwards. If register 9 bit 3 is 0, no calibration starts.
- R9: In legacy mode (register 12 bit 6 = 0), index i+16 reads and writes the same register as index i.
- R10: In extended mode (register 12 bit 6 = 1, the reset state), indices 16 to 31 are registers of their own.
- R11: Register 12 bits 3:0 always read REVISION (0xA by default) and bit 7 always reads 1. Bits 6:4 are writable.
- R12: Bit 4 of registers 0 and 1 always reads 0, and bit 5 of register 11 cannot be written by the host.
- R13: Reads of ports 2 and 3 return 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Port: 0 index, 1 data, 2 status, 3 polled |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The assertions check the following on every cycle: an index read during busy returns 0x80, and an accepted format write raises busy. A gated format write and any data write during busy leave the register contents alone. A calibration start raises the calibration flag, and reads of the revision bits, the fixed-zero bits and the spare ports return fixed values. Some behaviours need the bench's scenarios instead. These are the exact reset contents, readback after a full sweep of write patterns, and the end of the busy and calibration windows. The folding of upper indices in legacy mode and their separation in extended mode also rely on the bench.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned IDX_W = 5;
  localparam int unsigned NREG  = 1 << IDX_W;

  localparam logic [IDX_W-1:0] FMT_IDX     = 5'd8;
  localparam logic [IDX_W-1:0] CALCTL_IDX  = 5'd9;
  localparam logic [IDX_W-1:0] CALSTAT_IDX = 5'd11;
  localparam logic [IDX_W-1:0] MODE_IDX    = 5'd12;

  localparam int unsigned MCE_BIT     = 6;
  localparam int unsigned CALEN_BIT   = 3;
  localparam int unsigned CALBUSY_BIT = 5;
  localparam int unsigned EXT_BIT     = 6;

  typedef enum logic [1:0] {
    PORT_INDEX  = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_STATUS = 2'd2,
    PORT_POLL   = 2'd3
  } ccr_port_e;

  // Power-on contents of each indirect register.
  function automatic logic [7:0] ccr_reset_value(input logic [IDX_W-1:0] idx,
                                                 input logic [3:0] rev);
    logic [7:0] v;
    case (idx)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd9: v = 8'h08;
      5'd10:                                    v = 8'h02;
      5'd12:                                    v = {4'hC, rev};
      default:                                  v = 8'h00;
    endcase
    return v;
  endfunction

  // Bits the host may change in each register.
  function automatic logic [7:0] ccr_write_mask(input logic [IDX_W-1:0] idx);
    logic [7:0] m;
    case (idx)
      5'd0, 5'd1: m = 8'hEF;
      5'd11:      m = 8'hDF;
      5'd12:      m = 8'h70;
      default:    m = 8'hFF;
    endcase
    return m;
  endfunction

  // Legacy mode folds the upper half onto the lower sixteen registers.
  function automatic logic [IDX_W-1:0] ccr_map_index(input logic [IDX_W-1:0] idx,
                                                     input logic ext);
    return ext ? idx : {1'b0, idx[IDX_W-2:0]};
  endfunction
endpackage

// File: rtl/ccr_down_timer.sv
module ccr_down_timer #(
  parameter int unsigned   W        = 8,
  parameter logic [W-1:0]  RST_LOAD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         active
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= RST_LOAD;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/ccr_index_port.sv
module ccr_index_port
  import ccr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_mce,
  output logic [IDX_W-1:0] idx,
  output logic             mce,
  output logic             mce_fall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      mce <= 1'b0;
    end else if (wr_en) begin
      idx <= wr_idx;
      mce <= wr_mce;
    end
  end

  assign mce_fall = wr_en && mce && !wr_mce;
endmodule

// File: rtl/ccr_reg_file.sv
module ccr_reg_file
  import ccr_pkg::*;
#(
  parameter logic [3:0] REVISION = 4'hA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             cal_active,
  output logic [7:0]       rd_word,
  output logic             mode_ext,
  output logic             cal_en,
  output logic [7:0]       fmt_q
);
  logic [7:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    localparam logic [7:0]       RV = ccr_reset_value(GI, REVISION);
    localparam logic [7:0]       WM = ccr_write_mask(GI);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      q <= RV;
      else if (wr_en && wr_idx == GI)  q <= (q & ~WM) | (wdata & WM);
    end
    assign regs[g] = q;
  end

  always_comb begin
    rd_word = regs[rd_idx];
    if (rd_idx == CALSTAT_IDX) rd_word[CALBUSY_BIT] = cal_active;
  end

  assign mode_ext = regs[MODE_IDX][EXT_BIT];
  assign cal_en   = regs[CALCTL_IDX][CALEN_BIT];
  assign fmt_q    = regs[FMT_IDX];
endmodule

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
  import ccr_pkg::*;
#(
  parameter int unsigned INIT_CYCLES   = 8,
  parameter int unsigned RESYNC_CYCLES = 16,
  parameter int unsigned CAL_CYCLES    = 64,
  parameter logic [3:0]  REVISION      = 4'hA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  localparam int unsigned BUSY_MAX = (INIT_CYCLES > RESYNC_CYCLES) ? INIT_CYCLES : RESYNC_CYCLES;
  localparam int unsigned BUSY_W   = $clog2(BUSY_MAX + 1);
  localparam int unsigned CAL_W    = $clog2(CAL_CYCLES + 1);

  ccr_port_e port;
  assign port = ccr_port_e'(bus_addr);

  // Named events for the checker.
  logic             idx_wr, data_wr, data_rd, idx_rd;
  logic             busy, cal_active, mce, mce_fall, mode_ext, cal_en;
  logic             cal_start, fmt_commit, data_wr_ok, data_wr_drop;
  logic [IDX_W-1:0] cur_idx, eff_idx;
  logic [7:0]       rd_word, fmt_q;

  assign idx_wr  = bus_sel &&  bus_wr && port == PORT_INDEX;
  assign data_wr = bus_sel &&  bus_wr && port == PORT_DATA;
  assign idx_rd  = bus_sel && !bus_wr && port == PORT_INDEX;
  assign data_rd = bus_sel && !bus_wr && port == PORT_DATA;

  ccr_index_port u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (idx_wr),
    .wr_idx   (bus_wdata[IDX_W-1:0]),
    .wr_mce   (bus_wdata[MCE_BIT]),
    .idx      (cur_idx),
    .mce      (mce),
    .mce_fall (mce_fall)
  );

  assign eff_idx      = ccr_map_index(cur_idx, mode_ext);
  assign data_wr_ok   = data_wr && !busy && (eff_idx != FMT_IDX || mce);
  assign data_wr_drop = data_wr && !data_wr_ok;
  assign fmt_commit   = data_wr_ok && eff_idx == FMT_IDX;
  assign cal_start    = mce_fall && cal_en;

  ccr_down_timer #(.W(BUSY_W), .RST_LOAD(BUSY_W'(INIT_CYCLES))) u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fmt_commit),
    .load_val (BUSY_W'(RESYNC_CYCLES)),
    .active   (busy)
  );

  ccr_down_timer #(.W(CAL_W), .RST_LOAD('0)) u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cal_start),
    .load_val (CAL_W'(CAL_CYCLES)),
    .active   (cal_active)
  );

  ccr_reg_file #(.REVISION(REVISION)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (data_wr_ok),
    .wr_idx     (eff_idx),
    .wdata      (bus_wdata),
    .rd_idx     (eff_idx),
    .cal_active (cal_active),
    .rd_word    (rd_word),
    .mode_ext   (mode_ext),
    .cal_en     (cal_en),
    .fmt_q      (fmt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= 8'h00;
    end else if (idx_rd) begin
      bus_rdata <= busy ? 8'h80 : {1'b0, mce, 1'b0, cur_idx};
    end else if (data_rd) begin
      bus_rdata <= rd_word;
    end else if (bus_sel && !bus_wr) begin
      bus_rdata <= 8'h00;
    end
  end
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
  import ccr_pkg::*;
#(
  parameter logic [3:0] REVISION = 4'hA
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [7:0]       bus_rdata,
  input logic             busy,
  input logic             mce,
  input logic [IDX_W-1:0] eff_idx,
  input logic             fmt_commit,
  input logic             cal_start,
  input logic             cal_active,
  input logic [7:0]       rd_word,
  input logic [7:0]       fmt_q
);
  assert_idx_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && bus_addr == 2'd0 && busy |=> bus_rdata == 8'h80);

  assert_fmt_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == 2'd1 && eff_idx == FMT_IDX && !mce |=> $stable(fmt_q));

  assert_resync_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_commit |=> busy);

  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == 2'd1 && busy && eff_idx != CALSTAT_IDX
    |=> $stable(rd_word));

  assert_cal_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> cal_active);

  assert_revision_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && bus_addr == 2'd1 && eff_idx == MODE_IDX
    |=> bus_rdata[3:0] == REVISION && bus_rdata[7]);

  assert_ro_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && bus_addr == 2'd1 && (eff_idx == 5'd0 || eff_idx == 5'd1)
    |=> !bus_rdata[4]);

  assert_spare_ports_R13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && bus_addr[1] |=> bus_rdata == 8'h00);
endmodule

bind codec_ctl_regs ccr_checker #(.REVISION(REVISION)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .busy       (busy),
  .mce        (mce),
  .eff_idx    (eff_idx),
  .fmt_commit (fmt_commit),
  .cal_start  (cal_start),
  .cal_active (cal_active),
  .rd_word    (rd_word),
  .fmt_q      (fmt_q)
);

// File: tb/codec_ctl_regs_test.sv
`timescale 1ns/1ps
module codec_ctl_regs_test;
  localparam int INIT_C   = 8;
  localparam int RESYNC_C = 16;
  localparam int CAL_C    = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model [32];
  logic [7:0] rd;

  always #5 clk = ~clk;

  codec_ctl_regs #(.INIT_CYCLES(INIT_C), .RESYNC_CYCLES(RESYNC_C),
                   .CAL_CYCLES(CAL_C), .REVISION(4'hA)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [7:0] host_mask(input int i);
    if (i == 0 || i == 1) return 8'hEF;
    if (i == 11) return 8'hDF;
    if (i == 12) return 8'h70;
    return 8'hFF;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdp(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic model_write(input int i, input logic [7:0] d);
    model[i] = (model[i] & ~host_mask(i)) | (d & host_mask(i));
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rst_tab [16];
    rst_tab = '{8'h08, 8'h08, 8'h08, 8'h08, 8'h08, 8'h08, 8'h00, 8'h00,
                8'h00, 8'h08, 8'h02, 8'h00, 8'hCA, 8'h00, 8'h00, 8'h00};
    for (int i = 0; i < 32; i++) model[i] = (i < 16) ? rst_tab[i] : 8'h00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3: busy after reset, then R2 index readback
    rdp(2'd0, rd); check("R3 init busy", rd, 8'h80);
    repeat (INIT_C + 2) @(negedge clk);
    rdp(2'd0, rd); check("R2 index after init", rd, 8'h00);

    // R1 / R10: reset contents, upper half separate in extended mode
    for (int i = 0; i < 32; i++) begin
      wr(2'd0, 8'(i));
      rdp(2'd1, rd); check(i < 16 ? "R1 reset value" : "R10 upper reset", rd, model[i]);
    end

    // R4 / R5 / R11 / R12: full pattern sweep with mce clear
    for (int i = 0; i < 32; i++) begin
      logic [7:0] p;
      p = 8'((i * 37 + 5) ^ 8'h5A);
      if (i == 12) p = p | 8'h40;
      wr(2'd0, 8'(i));
      wr(2'd1, p);
      if (i != 8) model_write(i, p);
    end
    for (int i = 0; i < 32; i++) begin
      wr(2'd0, 8'(i));
      rdp(2'd1, rd);
      check(i == 8 ? "R5 fmt gated" : (i == 12 ? "R11 mode reg" :
            (i < 2 || i == 11 ? "R12 ro bits" : "R4 readback")), rd, model[i]);
    end
    // R4: read data held when no read strobe
    repeat (3) @(negedge clk);
    check("R4 rdata held", bus_rdata, model[31]);

    // R2: index and mce readback
    wr(2'd0, 8'h53);
    rdp(2'd0, rd); check("R2 index mce", rd, 8'h53);
    wr(2'd0, 8'h13);

    // R5 / R6 / R7: format write with mce set
    wr(2'd0, 8'h48);
    wr(2'd1, 8'h5B);
    rdp(2'd0, rd); check("R6 resync busy", rd, 8'h80);
    wr(2'd1, 8'h77);
    repeat (RESYNC_C + 2) @(negedge clk);
    rdp(2'd0, rd); check("R6 resync done", rd, 8'h48);
    rdp(2'd1, rd); check("R7 busy write dropped", rd, 8'h5B);
    model[8] = 8'h5B;
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h11);
    rdp(2'd1, rd); check("R5 fmt write without mce", rd, 8'h5B);

    // R8: calibration window
    wr(2'd0, 8'h09); wr(2'd1, 8'h08); model[9] = 8'h08;
    repeat (CAL_C + 2) @(negedge clk);
    wr(2'd0, 8'h4B);
    wr(2'd0, 8'h0B);
    rdp(2'd1, rd); check("R8 cal running", rd & 8'h20, 8'h20);
    repeat (CAL_C + 2) @(negedge clk);
    rdp(2'd1, rd); check("R8 cal ended", rd, model[11]);
    wr(2'd1, 8'hFF); model_write(11, 8'hFF);
    rdp(2'd1, rd); check("R12 cal bit not writable", rd, model[11]);
    wr(2'd0, 8'h09); wr(2'd1, 8'h00); model[9] = 8'h00;
    wr(2'd0, 8'h4B);
    wr(2'd0, 8'h0B);
    rdp(2'd1, rd); check("R8 no cal when disabled", rd, model[11]);

    // R9: legacy aliasing
    wr(2'd0, 8'h0C); wr(2'd1, 8'h00); model_write(12, 8'h00);
    for (int i = 0; i < 16; i++) begin
      if (i == 8 || i == 11 || i == 12) continue;
      wr(2'd0, 8'(i + 16));
      wr(2'd1, 8'(~(i * 11)));
      model_write(i, 8'(~(i * 11)));
    end
    for (int i = 0; i < 16; i++) begin
      wr(2'd0, 8'(i));
      rdp(2'd1, rd); check("R9 legacy low", rd, model[i]);
      wr(2'd0, 8'(i + 16));
      rdp(2'd1, rd); check("R9 legacy alias", rd, model[i]);
    end

    // R10: back to extended, upper registers kept their own values
    wr(2'd0, 8'h0C); wr(2'd1, 8'h40); model_write(12, 8'h40);
    for (int i = 16; i < 32; i++) begin
      wr(2'd0, 8'(i));
      rdp(2'd1, rd); check("R10 upper separate", rd, model[i]);
    end

    // R13: spare ports
    wr(2'd0, 8'h05);
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    rdp(2'd2, rd); check("R13 port2", rd, 8'h00);
    rdp(2'd3, rd); check("R13 port3", rd, 8'h00);
    rdp(2'd0, rd); check("R13 index untouched", rd, 8'h05);
    rdp(2'd1, rd); check("R13 regs untouched", rd, model[5]);

    finish_run();
  end
endmodule